// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction in the execute stage of a five-stage in-order integer pipeline, where each ALU operand comes from. An older instruction may not yet have written its result to the register file, so the block compares the two source register indices of the executing instruction with the destination index and write enable held in the execute/memory pipeline register and in the memory/write-back pipeline register. On a match, the fresher value is routed to the ALU in place of the stale register-file value. When both later stages target the needed register, the younger producer (execute/memory) wins. Register index 0 is never bypassed.

A second, independent path serves stores in the memory stage. When the store's data register is the destination of a load that is now in write-back, the store write data is taken from the loaded value instead of the value carried down the pipe. A producer three or more instructions older needs no bypass, because the register file writes early in the cycle and the read in the same cycle sees the new value.

The unit is purely combinational and holds no state. It has no valid/ready handshake: every input is a level from a pipeline register, and every output is valid in the same cycle, so back-pressure does not apply. The three data multiplexers are included so that the block can be checked at the data level.

Top module: `opfwd_unit`

## Requirements
- R1: With no qualifying match, an operand select is 0 and the operand equals its register-file value.
- R2: When `exm_we` is 1 and `exm_dst` equals `ex_rs` (nonzero), `sel_a` is 2 and `opnd_a` equals `exm_alu`.
- R3: When `mwb_we` is 1 and `mwb_dst` equals `ex_rs` (nonzero), and the execute/memory stage is not a valid writer of that register, `sel_a` is 1 and `opnd_a` equals `mwb_val`.
- R4: When both stages validly write the register named by the source field, the select is 2 and the execute/memory value is used.
- R5: A stage whose write enable is 0 is never selected, even when its destination matches.
- R6: A source field of 0 always gives select 0 and the register-file value.
- R7: Operand B applies the same rules with `ex_rt`, `ex_rt_val`, `sel_b` and `opnd_b`, independently of operand A.
- R8: When `mem_is_store`, `wb_is_load` and `mwb_we` are all 1 and `mem_src` equals `mwb_dst` (nonzero), `st_sel` is 1 and `st_data` equals `mwb_val`.
- R9: In every other case `st_sel` is 0 and `st_data` equals `mem_store_val`.
- R10: In a subtract-then-and/or/add/store sequence with registers at index+100, each consumer of register 2 receives -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register index of the execute-stage instruction |
| ex_rt | input | 5 | Second source register index of the execute-stage instruction |
| ex_rs_val | input | 32 | Register-file value read for the first source |
| ex_rt_val | input | 32 | Register-file value read for the second source |
| exm_we | input | 1 | Execute/memory stage writes a register |
| exm_dst | input | 5 | Execute/memory stage destination index |
| exm_alu | input | 32 | ALU result held in execute/memory |
| mwb_we | input | 1 | Memory/write-back stage writes a register |
| mwb_dst | input | 5 | Memory/write-back stage destination index |
| mwb_val | input | 32 | Write-back value held in memory/write-back |
| wb_is_load | input | 1 | Write-back instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_src | input | 5 | Memory-stage store data register index |
| mem_store_val | input | 32 | Store data carried down the pipeline |
| sel_a | output | 2 | Operand A source: 0 register file, 1 write-back, 2 execute/memory |
| sel_b | output | 2 | Operand B source, same codes |
| opnd_a | output | 32 | Selected ALU operand A |
| opnd_b | output | 32 | Selected ALU operand B |
| st_sel | output | 1 | Store data source: 0 pipeline, 1 loaded value |
| st_data | output | 32 | Selected store write data |

## Verification
On every evaluation the assertions check that each output value agrees with the select code that chose it, that register 0 and disabled stages are never selected, that the younger producer always wins a double match, and that the store bypass fires only for a store behind a load. Only the bench's sweeps can show that each select is exactly right across all combinations of index equality and write enable, that the two operands do not interfere, and that a real dependent sequence delivers the correct arithmetic value to every consumer.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  // Operand source codes; the ALU input muxes decode these values.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_WBACK   = 2'd1,
    SRC_EXMEM   = 2'd2
  } opsrc_e;

  // Store data source codes.
  typedef enum logic {
    ST_PIPE = 1'b0,
    ST_LOAD = 1'b1
  } stsrc_e;

endpackage

// File: rtl/fwd_hit.sv
// One producer/consumer comparison: a valid writer whose destination
// names the consumer's nonzero source register.
module fwd_hit #(
  parameter int REG_W = 5
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] dst_idx,
  input  logic [REG_W-1:0] src_idx,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_IDX = '0;

  logic idx_eq;
  logic src_live;

  always_comb begin
    idx_eq   = (dst_idx == src_idx);
    src_live = (src_idx != ZERO_IDX);
    hit      = wr_en && idx_eq && src_live;
  end
endmodule

// File: rtl/fwd_opsel.sv
// Source selection for one ALU operand; the younger stage has priority.
module fwd_opsel
  import opfwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             src_idx_i,
  input  logic [REG_W-1:0] src_idx,
  input  logic             exm_we,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             mwb_we,
  input  logic [REG_W-1:0] mwb_dst,
  output opsrc_e           sel
);
  logic hit_exm;
  logic hit_mwb;

  fwd_hit #(.REG_W(REG_W)) u_hit_exm (
    .wr_en   (exm_we),
    .dst_idx (exm_dst),
    .src_idx (src_idx),
    .hit     (hit_exm)
  );

  fwd_hit #(.REG_W(REG_W)) u_hit_mwb (
    .wr_en   (mwb_we),
    .dst_idx (mwb_dst),
    .src_idx (src_idx),
    .hit     (hit_mwb)
  );

  always_comb begin
    sel = SRC_REGFILE;
    if (src_idx_i) begin
      if (hit_exm)      sel = SRC_EXMEM;
      else if (hit_mwb) sel = SRC_WBACK;
    end
  end
endmodule

// File: rtl/fwd_mux3.sv
// Three-way operand multiplexer driven by an operand source code.
module fwd_mux3
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opsrc_e            sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] em_val,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    unique case (sel)
      SRC_EXMEM: dout = em_val;
      SRC_WBACK: dout = wb_val;
      default:   dout = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_store_byp.sv
// Memory-stage store data bypass from a load sitting in write-back.
module fwd_store_byp
  import opfwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              mem_is_store,
  input  logic              wb_is_load,
  input  logic              mwb_we,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic [REG_W-1:0]  mem_src,
  input  logic [DATA_W-1:0] mwb_val,
  input  logic [DATA_W-1:0] mem_store_val,
  output stsrc_e            sel,
  output logic [DATA_W-1:0] st_data
);
  logic pair_ok;
  logic hit;

  assign pair_ok = mem_is_store && wb_is_load && mwb_we;

  fwd_hit #(.REG_W(REG_W)) u_hit_ld (
    .wr_en   (pair_ok),
    .dst_idx (mwb_dst),
    .src_idx (mem_src),
    .hit     (hit)
  );

  always_comb begin
    sel     = hit ? ST_LOAD : ST_PIPE;
    st_data = (sel == ST_LOAD) ? mwb_val : mem_store_val;
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic [DATA_W-1:0] ex_rs_val,
  input  logic [DATA_W-1:0] ex_rt_val,
  input  logic              exm_we,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic [DATA_W-1:0] exm_alu,
  input  logic              mwb_we,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic [DATA_W-1:0] mwb_val,
  input  logic              wb_is_load,
  input  logic              mem_is_store,
  input  logic [REG_W-1:0]  mem_src,
  input  logic [DATA_W-1:0] mem_store_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              st_sel,
  output logic [DATA_W-1:0] st_data
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0]  op_idx [NUM_OPS];
  logic [DATA_W-1:0] op_rf  [NUM_OPS];
  logic [DATA_W-1:0] op_out [NUM_OPS];
  opsrc_e            op_sel [NUM_OPS];
  stsrc_e            st_code;

  assign op_idx[0] = ex_rs;
  assign op_idx[1] = ex_rt;
  assign op_rf[0]  = ex_rs_val;
  assign op_rf[1]  = ex_rt_val;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_opsel #(.REG_W(REG_W)) u_sel (
      .src_idx_i (1'b1),
      .src_idx   (op_idx[g]),
      .exm_we    (exm_we),
      .exm_dst   (exm_dst),
      .mwb_we    (mwb_we),
      .mwb_dst   (mwb_dst),
      .sel       (op_sel[g])
    );

    fwd_mux3 #(.DATA_W(DATA_W)) u_mux (
      .sel    (op_sel[g]),
      .rf_val (op_rf[g]),
      .wb_val (mwb_val),
      .em_val (exm_alu),
      .dout   (op_out[g])
    );
  end

  fwd_store_byp #(.REG_W(REG_W), .DATA_W(DATA_W)) u_st (
    .mem_is_store  (mem_is_store),
    .wb_is_load    (wb_is_load),
    .mwb_we        (mwb_we),
    .mwb_dst       (mwb_dst),
    .mem_src       (mem_src),
    .mwb_val       (mwb_val),
    .mem_store_val (mem_store_val),
    .sel           (st_code),
    .st_data       (st_data)
  );

  assign sel_a  = op_sel[0];
  assign sel_b  = op_sel[1];
  assign opnd_a = op_out[0];
  assign opnd_b = op_out[1];
  assign st_sel = st_code;
endmodule

// File: rtl/opfwd_chk.sv
module opfwd_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  ex_rs,
  input logic [REG_W-1:0]  ex_rt,
  input logic [DATA_W-1:0] ex_rs_val,
  input logic [DATA_W-1:0] ex_rt_val,
  input logic              exm_we,
  input logic [REG_W-1:0]  exm_dst,
  input logic [DATA_W-1:0] exm_alu,
  input logic              mwb_we,
  input logic [REG_W-1:0]  mwb_dst,
  input logic [DATA_W-1:0] mwb_val,
  input logic              wb_is_load,
  input logic              mem_is_store,
  input logic [REG_W-1:0]  mem_src,
  input logic [DATA_W-1:0] mem_store_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              st_sel,
  input logic [DATA_W-1:0] st_data
);
  always_comb begin
    // R2
    a_exmem_data_chk: assert (sel_a != 2'd2 || opnd_a == exm_alu)
      else $error("operand A code 2 without execute/memory data");
    // R3
    a_wback_data_chk: assert (sel_a != 2'd1 || opnd_a == mwb_val)
      else $error("operand A code 1 without write-back data");
    // R1
    a_rf_data_chk: assert (sel_a != 2'd0 || opnd_a == ex_rs_val)
      else $error("operand A code 0 without register-file data");
    // R7
    b_data_chk: assert ((sel_b != 2'd0 || opnd_b == ex_rt_val) &&
                        (sel_b != 2'd1 || opnd_b == mwb_val) &&
                        (sel_b != 2'd2 || opnd_b == exm_alu))
      else $error("operand B data does not follow its code");
    // R4
    youngest_wins_chk: assert (!(exm_we && exm_dst == ex_rs && ex_rs != '0) || sel_a == 2'd2)
      else $error("younger producer not preferred");
    // R5
    disabled_stage_chk: assert ((exm_we || sel_a != 2'd2) && (mwb_we || sel_a != 2'd1) &&
                                (exm_we || sel_b != 2'd2) && (mwb_we || sel_b != 2'd1))
      else $error("stage with write enable low was selected");
    // R6
    zero_reg_chk: assert ((ex_rs != '0 || sel_a == 2'd0) && (ex_rt != '0 || sel_b == 2'd0))
      else $error("register zero forwarded");
    // R8
    st_byp_cond_chk: assert (!st_sel || (mem_is_store && wb_is_load && mwb_we &&
                                         mem_src == mwb_dst && mem_src != '0))
      else $error("store bypass without load-to-store pair");
    // R9
    st_data_chk: assert (st_sel ? (st_data == mwb_val) : (st_data == mem_store_val))
      else $error("store data does not follow its select");
    // R2
    exm_dst_use_chk: assert (sel_a != 2'd2 || exm_dst == ex_rs)
      else $error("execute/memory selected with mismatched index");
  end
endmodule

bind opfwd_unit opfwd_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .ex_rs         (ex_rs),
  .ex_rt         (ex_rt),
  .ex_rs_val     (ex_rs_val),
  .ex_rt_val     (ex_rt_val),
  .exm_we        (exm_we),
  .exm_dst       (exm_dst),
  .exm_alu       (exm_alu),
  .mwb_we        (mwb_we),
  .mwb_dst       (mwb_dst),
  .mwb_val       (mwb_val),
  .wb_is_load    (wb_is_load),
  .mem_is_store  (mem_is_store),
  .mem_src       (mem_src),
  .mem_store_val (mem_store_val),
  .sel_a         (sel_a),
  .sel_b         (sel_b),
  .opnd_a        (opnd_a),
  .opnd_b        (opnd_b),
  .st_sel        (st_sel),
  .st_data       (st_data)
);

// File: tb/opfwd_unit_tb.sv
module opfwd_unit_tb;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] ex_rs, ex_rt, exm_dst, mwb_dst, mem_src;
  logic [DW-1:0] ex_rs_val, ex_rt_val, exm_alu, mwb_val, mem_store_val;
  logic exm_we, mwb_we, wb_is_load, mem_is_store;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, st_data;
  logic st_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  opfwd_unit #(.REG_W(RW), .DATA_W(DW)) u_dut (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
    .exm_we(exm_we), .exm_dst(exm_dst), .exm_alu(exm_alu),
    .mwb_we(mwb_we), .mwb_dst(mwb_dst), .mwb_val(mwb_val),
    .wb_is_load(wb_is_load), .mem_is_store(mem_is_store), .mem_src(mem_src),
    .mem_store_val(mem_store_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .st_sel(st_sel), .st_data(st_data)
  );

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ex_rs = '0; ex_rt = '0; ex_rs_val = '0; ex_rt_val = '0;
    exm_we = 0; exm_dst = '0; exm_alu = '0;
    mwb_we = 0; mwb_dst = '0; mwb_val = '0;
    wb_is_load = 0; mem_is_store = 0; mem_src = '0; mem_store_val = '0;
  endtask

  function automatic int exp_code(int src, int ewe, int ed, int wwe, int wd);
    if (src != 0 && ewe != 0 && ed == src) return 2;
    if (src != 0 && wwe != 0 && wd == src) return 1;
    return 0;
  endfunction

  function automatic string tag_for(int src, int ewe, int ed, int wwe, int wd);
    if (src == 0) return "R6";
    if (ewe != 0 && ed == src && wwe != 0 && wd == src) return "R4";
    if (ewe != 0 && ed == src) return "R2";
    if (wwe != 0 && wd == src) return "R3";
    if (ed == src || wd == src) return "R5";
    return "R1";
  endfunction

  // One cycle of the dependent sequence: drive at posedge, sample at negedge.
  task automatic seq_step(int rs, int rt, logic [DW-1:0] rsv, logic [DW-1:0] rtv,
                          int ed, logic [DW-1:0] ev, int wd, logic [DW-1:0] wv);
    @(posedge clk);
    ex_rs = RW'(rs); ex_rt = RW'(rt); ex_rs_val = rsv; ex_rt_val = rtv;
    exm_we = 1; exm_dst = RW'(ed); exm_alu = ev;
    mwb_we = (wd != 0); mwb_dst = RW'(wd); mwb_val = wv;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #500us;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] r2, and_r, or_r;
    clear_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state: all selects zero
    check("R1", "idle sel_a", DW'(sel_a), 0);
    check("R1", "idle sel_b", DW'(sel_b), 0);
    check("R9", "idle st_sel", DW'(st_sel), 0);

    // Sweep indices 0..3 for all four fields and both write enables.
    for (int rs = 0; rs < 4; rs++)
      for (int rt = 0; rt < 4; rt++)
        for (int ed = 0; ed < 4; ed++)
          for (int wd = 0; wd < 4; wd++)
            for (int we = 0; we < 4; we++) begin
              int ca, cb;
              logic [DW-1:0] ea, eb;
              @(posedge clk);
              ex_rs = RW'(rs); ex_rt = RW'(rt);
              ex_rs_val = 32'h1000_0000 + DW'(rs);
              ex_rt_val = 32'h2000_0000 + DW'(rt);
              exm_we = we[0]; exm_dst = RW'(ed); exm_alu = 32'hA0A0_0000 + DW'(ed);
              mwb_we = we[1]; mwb_dst = RW'(wd); mwb_val = 32'h5B5B_0000 + DW'(wd);
              @(negedge clk);
              ca = exp_code(rs, we & 1, ed, we >> 1, wd);
              cb = exp_code(rt, we & 1, ed, we >> 1, wd);
              ea = (ca == 2) ? exm_alu : (ca == 1) ? mwb_val : ex_rs_val;
              eb = (cb == 2) ? exm_alu : (cb == 1) ? mwb_val : ex_rt_val;
              check(tag_for(rs, we & 1, ed, we >> 1, wd), "sel_a", DW'(sel_a), DW'(ca));
              check(tag_for(rs, we & 1, ed, we >> 1, wd), "opnd_a", opnd_a, ea);
              check("R7", "sel_b", DW'(sel_b), DW'(cb));
              check("R7", "opnd_b", opnd_b, eb);
            end

    // Store bypass sweep: indices 0..3 and all flag combinations.
    clear_inputs();
    for (int ms = 0; ms < 4; ms++)
      for (int wd = 0; wd < 4; wd++)
        for (int fl = 0; fl < 8; fl++) begin
          bit hit;
          @(posedge clk);
          mem_src = RW'(ms); mwb_dst = RW'(wd);
          mem_is_store = fl[0]; wb_is_load = fl[1]; mwb_we = fl[2];
          mwb_val = 32'hCAFE_0000 + DW'(wd);
          mem_store_val = 32'h0BAD_0000 + DW'(ms);
          @(negedge clk);
          hit = (fl == 7) && (ms == wd) && (ms != 0);
          check(hit ? "R8" : "R9", "st_sel", DW'(st_sel), DW'(hit));
          check(hit ? "R8" : "R9", "st_data", st_data, hit ? mwb_val : mem_store_val);
        end

    // R10 dependent sequence, registers hold index+100.
    clear_inputs();
    r2    = 32'd101 - 32'd103;
    and_r = r2 & 32'd105;
    or_r  = 32'd106 | r2;
    // and r12,r2,r5 in EX; sub in EX/MEM
    seq_step(2, 5, 32'd102, 32'd105, 2, r2, 0, 0);
    check("R10", "and operand r2", opnd_a, r2);
    check("R10", "and operand r5", opnd_b, 32'd105);
    // or r13,r6,r2 in EX; and in EX/MEM; sub in MEM/WB
    seq_step(6, 2, 32'd106, 32'd102, 12, and_r, 2, r2);
    check("R10", "or operand r6", opnd_a, 32'd106);
    check("R10", "or operand r2", opnd_b, r2);
    // add r14,r2,r2: register file already holds the new value
    seq_step(2, 2, r2, r2, 13, or_r, 12, and_r);
    check("R10", "add operand a", opnd_a, r2);
    check("R10", "add operand b", opnd_b, r2);
    check("R10", "add sel_a", DW'(sel_a), 0);
    // sw r15,100(r2)
    seq_step(2, 15, r2, 32'd115, 14, r2 + r2, 13, or_r);
    check("R10", "store base r2", opnd_a, r2);
    check("R10", "store data r15", opnd_b, 32'd115);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule